// File: doc/BRIEF.md
# Preamble Correlator and Receive Frame Timing

This block finds the start of a burst in a stream of complex baseband symbols and then produces the timing of everything that follows it. Each valid input symbol enters a sliding window the length of the known preamble. The window is correlated against the preamble's stored signs, and the result is normalised by the window's amplitude sum. When the normalised metric exceeds a programmable threshold, the block marks that symbol as the end of the preamble.

After a detection the block walks through the training section and then the data section. It labels each data symbol either as a pilot or as payload. The pilot pattern follows a pilot-density value that the host can change at runtime. Symbols leave the block one cycle after they enter, unchanged, with the flags attached. Downstream stages use the flags to schedule channel estimation and demapping.

Top module: `preamble_frame_sync`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `frame_start`, `pilot_flag` and `data_flag` are 0. Reset empties the correlation window, which then counts as all zeros, and puts the block back into search, so a preamble cut in two by a reset is not detected.
- R2: Each symbol with `in_valid` high appears one cycle later on `out_i`/`out_q` unchanged, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low and all three flags low on the next cycle.
- R3: The window holds the last 128 valid symbols, index 0 oldest. Reference sign k is negative when the bit-parity of (k AND (k>>1)) is 1, and positive otherwise. C is the sum of the window symbols, each multiplied by its reference sign. P is the sum of |I|+|Q| over the window. A symbol whose C is zero is never detected.
- R4: In search, the newest symbol is a detection when |C|²·256 > `det_thresh`·P² and P ≥ 2048. For that symbol only, `frame_start` is high for one output cycle.
- R5: A window whose metric does not pass the R4 test, for example noise or a weakly matching burst under a high threshold, raises no flag.
- R6: The 128 valid symbols that follow a detection are training symbols, and all three flags stay low for them.
- R7: The next 2048 valid symbols form the data section. Each of them has exactly one of `pilot_flag` and `data_flag` high. With n counting the data symbols from 0, `pilot_flag` is high when (n mod 16) < λ, which gives 16·λ pilots in each 256-symbol subframe.
- R8: λ is taken from `pilot_reps` on the detecting symbol. Changes to `pilot_reps` during the training or data section do not affect the current frame.
- R9: From a detection until the last data symbol, preambles in the stream do not produce `frame_start`. Search resumes with the symbol that follows the last data symbol.
- R10: Cycles with `in_valid` low neither move the window nor advance the training or data counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input symbol qualifier |
| in_i | input | 8 | In-phase sample, signed |
| in_q | input | 8 | Quadrature sample, signed |
| det_thresh | input | 8 | Detection threshold, unsigned fraction of 256 |
| pilot_reps | input | 5 | Pilot density λ, sampled at detection |
| out_valid | output | 1 | Output symbol qualifier |
| out_i | output | 8 | Delayed in-phase sample |
| out_q | output | 8 | Delayed quadrature sample |
| frame_start | output | 1 | One-cycle mark on the last preamble symbol |
| pilot_flag | output | 1 | Data-section symbol is a pilot |
| data_flag | output | 1 | Data-section symbol is payload |

## Verification
The hardest situation to create is a full-strength preamble arriving while a frame is still being counted, combined with a density change that lands mid-frame. The stimulus plants a complete preamble inside the data section of the first frame and changes `pilot_reps` in the same frame. It then starts a new preamble on the exact cycle after the last data symbol, so that both the ignored detection and the instant re-arm are exercised. Two other cases are reached with their own streams. One is a preamble split by a reset. The other is a preamble whose second half is negated, which makes C exactly zero.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_TRAIN  = 2'd1,
    ST_DATA   = 2'd2
  } sync_state_e;

  // Sign of reference tap k: 1 means the tap subtracts.
  function automatic logic ref_negative(input int unsigned k);
    logic [31:0] v;
    v = k & (k >> 1);
    return ^v;
  endfunction

endpackage

// File: rtl/fsync_corr.sv
module fsync_corr
  import fsync_pkg::*;
#(
  parameter int SW      = 8,
  parameter int PRE_LEN = 128,
  parameter int CW      = SW + $clog2(PRE_LEN) + 1,
  parameter int PW      = SW + 1 + $clog2(PRE_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic signed [CW-1:0] corr_i,
  output logic signed [CW-1:0] corr_q,
  output logic        [PW-1:0] pwr
);

  function automatic logic [PRE_LEN-1:0] build_ref();
    logic [PRE_LEN-1:0] r;
    for (int k = 0; k < PRE_LEN; k++) r[k] = ref_negative(k);
    return r;
  endfunction

  localparam logic [PRE_LEN-1:0] REF_NEG = build_ref();

  logic signed [SW-1:0] hist_i [PRE_LEN-1];
  logic signed [SW-1:0] hist_q [PRE_LEN-1];
  logic signed [SW-1:0] win_i  [PRE_LEN];
  logic signed [SW-1:0] win_q  [PRE_LEN];
  logic signed [CW-1:0] tap_i  [PRE_LEN];
  logic signed [CW-1:0] tap_q  [PRE_LEN];
  logic        [PW-1:0] mag    [PRE_LEN];

  // Window: stored history plus the symbol presented this cycle.
  for (genvar k = 0; k < PRE_LEN - 1; k++) begin : g_win
    assign win_i[k] = hist_i[k];
    assign win_q[k] = hist_q[k];
  end
  assign win_i[PRE_LEN-1] = in_i;
  assign win_q[PRE_LEN-1] = in_q;

  // Delay line advances only on accepted symbols.
  for (genvar k = 0; k < PRE_LEN - 1; k++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_i[k] <= '0;
        hist_q[k] <= '0;
      end else if (shift_en) begin
        hist_i[k] <= win_i[k+1];
        hist_q[k] <= win_q[k+1];
      end
    end
  end

  // Sign taps: add or subtract, plus an L1 magnitude per tap.
  for (genvar k = 0; k < PRE_LEN; k++) begin : g_tap
    logic signed [CW-1:0] ext_i, ext_q;
    logic signed [SW:0]   wi, wq;
    logic        [SW:0]   ai, aq;
    assign ext_i = CW'(win_i[k]);
    assign ext_q = CW'(win_q[k]);
    if (REF_NEG[k]) begin : g_neg
      assign tap_i[k] = -ext_i;
      assign tap_q[k] = -ext_q;
    end else begin : g_pos
      assign tap_i[k] = ext_i;
      assign tap_q[k] = ext_q;
    end
    assign wi = (SW+1)'(win_i[k]);
    assign wq = (SW+1)'(win_q[k]);
    assign ai = wi[SW] ? -wi : wi;
    assign aq = wq[SW] ? -wq : wq;
    assign mag[k] = PW'(ai) + PW'(aq);
  end

  always_comb begin
    corr_i = '0;
    corr_q = '0;
    pwr    = '0;
    for (int k = 0; k < PRE_LEN; k++) begin
      corr_i = corr_i + tap_i[k];
      corr_q = corr_q + tap_q[k];
      pwr    = pwr + mag[k];
    end
  end

endmodule

// File: rtl/fsync_metric.sv
module fsync_metric #(
  parameter int CW        = 16,
  parameter int PW        = 16,
  parameter int TW        = 8,
  parameter int TF        = 8,
  parameter int PWR_FLOOR = 2048
) (
  input  logic signed [CW-1:0] corr_i,
  input  logic signed [CW-1:0] corr_q,
  input  logic        [PW-1:0] pwr,
  input  logic        [TW-1:0] thresh,
  output logic                 hit
);

  localparam int MAGW = 2 * CW + 1;
  localparam int LHSW = MAGW + TF;
  localparam int RHSW = TW + 2 * PW;
  localparam int CMPW = (LHSW > RHSW) ? LHSW : RHSW;

  logic signed [2*CW-1:0] sq_i, sq_q;
  logic        [MAGW-1:0] mag2;
  logic        [2*PW-1:0] pwr2;
  logic        [RHSW-1:0] scaled;
  logic        [CMPW-1:0] lhs, rhs;
  logic                   energetic;

  always_comb begin
    sq_i   = $signed({{CW{corr_i[CW-1]}}, corr_i}) * $signed({{CW{corr_i[CW-1]}}, corr_i});
    sq_q   = $signed({{CW{corr_q[CW-1]}}, corr_q}) * $signed({{CW{corr_q[CW-1]}}, corr_q});
    mag2   = {1'b0, sq_i} + {1'b0, sq_q};
    pwr2   = {{PW{1'b0}}, pwr} * {{PW{1'b0}}, pwr};
    scaled = {{(RHSW-TW){1'b0}}, thresh} * {{TW{1'b0}}, pwr2};
    lhs    = {{(CMPW-MAGW){1'b0}}, mag2} << TF;
    rhs    = {{(CMPW-RHSW){1'b0}}, scaled};
    energetic = (pwr >= PW'(PWR_FLOOR));
    hit    = energetic && (lhs > rhs);
  end

endmodule

// File: rtl/fsync_timing.sv
module fsync_timing
  import fsync_pkg::*;
#(
  parameter int TRAIN_LEN = 128,
  parameter int DATA_LEN  = 2048,
  parameter int GROUP_LEN = 16,
  parameter int LPW       = $clog2(GROUP_LEN) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           hit,
  input  logic [LPW-1:0] reps,
  output logic           frame_o,
  output logic           pilot_o,
  output logic           data_o
);

  localparam int SPAN = (DATA_LEN > TRAIN_LEN) ? DATA_LEN : TRAIN_LEN;
  localparam int CNTW = $clog2(SPAN);
  localparam int GBW  = $clog2(GROUP_LEN);

  sync_state_e     st_q, st_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [LPW-1:0]  reps_q, reps_d;
  logic [LPW-1:0]  slot;

  assign slot = LPW'(cnt_q[GBW-1:0]);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    reps_d  = reps_q;
    frame_o = 1'b0;
    pilot_o = 1'b0;
    data_o  = 1'b0;
    unique case (st_q)
      ST_SEARCH: begin
        if (step && hit) begin
          frame_o = 1'b1;
          st_d    = ST_TRAIN;
          cnt_d   = '0;
          reps_d  = reps;
        end
      end
      ST_TRAIN: begin
        if (step) begin
          if (cnt_q == CNTW'(TRAIN_LEN - 1)) begin
            st_d  = ST_DATA;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNTW'(1);
          end
        end
      end
      ST_DATA: begin
        if (step) begin
          pilot_o = (slot < reps_q);
          data_o  = !pilot_o;
          if (cnt_q == CNTW'(DATA_LEN - 1)) begin
            st_d  = ST_SEARCH;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNTW'(1);
          end
        end
      end
      default: begin
        st_d  = ST_SEARCH;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      cnt_q  <= '0;
      reps_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      reps_q <= reps_d;
    end
  end

endmodule

// File: rtl/preamble_frame_sync.sv
module preamble_frame_sync #(
  parameter int SW        = 8,
  parameter int PRE_LEN   = 128,
  parameter int TRAIN_LEN = 128,
  parameter int SUB_LEN   = 256,
  parameter int SUB_CNT   = 8,
  parameter int GROUP_LEN = 16,
  parameter int TW        = 8,
  parameter int TF        = 8,
  parameter int PWR_FLOOR = 2048,
  parameter int LPW       = $clog2(GROUP_LEN) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  input  logic        [TW-1:0] det_thresh,
  input  logic       [LPW-1:0] pilot_reps,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_i,
  output logic signed [SW-1:0] out_q,
  output logic                 frame_start,
  output logic                 pilot_flag,
  output logic                 data_flag
);

  localparam int DATA_LEN = SUB_CNT * SUB_LEN;
  localparam int CW       = SW + $clog2(PRE_LEN) + 1;
  localparam int PW       = SW + 1 + $clog2(PRE_LEN);

  logic signed [CW-1:0] corr_i, corr_q;
  logic        [PW-1:0] pwr;
  logic                 hit;
  logic                 frm_d, plt_d, dat_d;

  fsync_corr #(.SW(SW), .PRE_LEN(PRE_LEN), .CW(CW), .PW(PW)) u_corr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .corr_i   (corr_i),
    .corr_q   (corr_q),
    .pwr      (pwr)
  );

  fsync_metric #(.CW(CW), .PW(PW), .TW(TW), .TF(TF), .PWR_FLOOR(PWR_FLOOR)) u_metric (
    .corr_i (corr_i),
    .corr_q (corr_q),
    .pwr    (pwr),
    .thresh (det_thresh),
    .hit    (hit)
  );

  fsync_timing #(
    .TRAIN_LEN (TRAIN_LEN),
    .DATA_LEN  (DATA_LEN),
    .GROUP_LEN (GROUP_LEN),
    .LPW       (LPW)
  ) u_timing (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (in_valid),
    .hit     (hit),
    .reps    (pilot_reps),
    .frame_o (frm_d),
    .pilot_o (plt_d),
    .data_o  (dat_d)
  );

  // Flags and qualifier every cycle; sample path only on accepted symbols.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      frame_start <= 1'b0;
      pilot_flag  <= 1'b0;
      data_flag   <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      frame_start <= frm_d;
      pilot_flag  <= plt_d;
      data_flag   <= dat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_i <= '0;
      out_q <= '0;
    end else if (in_valid) begin
      out_i <= in_i;
      out_q <= in_q;
    end
  end

endmodule

// File: rtl/preamble_frame_sync_chk.sv
module preamble_frame_sync_chk #(
  parameter int SW        = 8,
  parameter int TRAIN_LEN = 128,
  parameter int DATA_LEN  = 2048
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [SW-1:0] in_i,
  input logic [SW-1:0] in_q,
  input logic          out_valid,
  input logic [SW-1:0] out_i,
  input logic [SW-1:0] out_q,
  input logic          frame_start,
  input logic          pilot_flag,
  input logic          data_flag
);

  localparam int TOTAL = TRAIN_LEN + DATA_LEN;
  localparam int LW    = $clog2(TOTAL + 1);

  // Output symbols still owed to the frame most recently marked.
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (frame_start) begin
      left <= LW'(TOTAL);
    end else if (out_valid && left != '0) begin
      left <= left - LW'(1);
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !frame_start && !pilot_flag && !data_flag);

  // R2
  sample_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_i == $past(in_i)) && (out_q == $past(in_q)));

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, pilot_flag, data_flag}));

  // R6
  train_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && left > LW'(DATA_LEN)) |-> !pilot_flag && !data_flag);

  // R7
  data_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && left != '0 && left <= LW'(DATA_LEN)) |-> (pilot_flag || data_flag));

  // R9
  frame_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (left == '0) && out_valid);

  // R6
  search_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0) |-> !pilot_flag && !data_flag);

endmodule

bind preamble_frame_sync preamble_frame_sync_chk #(
  .SW        (SW),
  .TRAIN_LEN (TRAIN_LEN),
  .DATA_LEN  (SUB_CNT * SUB_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_i        (in_i),
  .in_q        (in_q),
  .out_valid   (out_valid),
  .out_i       (out_i),
  .out_q       (out_q),
  .frame_start (frame_start),
  .pilot_flag  (pilot_flag),
  .data_flag   (data_flag)
);

// File: tb/preamble_frame_sync_test.sv
module preamble_frame_sync_test;

  localparam int L     = 128;
  localparam int TRAIN = 128;
  localparam int DATA  = 2048;
  localparam int GRP   = 16;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic signed [7:0] in_i, in_q;
  logic        [7:0] det_thresh;
  logic        [4:0] pilot_reps;
  logic              out_valid;
  logic signed [7:0] out_i, out_q;
  logic              frame_start, pilot_flag, data_flag;

  preamble_frame_sync uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_i (in_i), .in_q (in_q),
    .det_thresh (det_thresh), .pilot_reps (pilot_reps),
    .out_valid (out_valid), .out_i (out_i), .out_q (out_q),
    .frame_start (frame_start), .pilot_flag (pilot_flag), .data_flag (data_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors;
  int misses;
  int dut_frames;

  // reference model state
  int    win_i[$];
  int    win_q[$];
  int    m_state;
  int    m_cnt;
  int    m_lp;
  int    cfg_thr;
  int    cfg_lp;
  string phase_tag;
  bit    e_valid, e_frame, e_pilot, e_data;
  int    e_i, e_q;
  string e_tag;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  task automatic miss(string tag, string what, longint act, longint exp);
    misses++;
    $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
  endtask

  function automatic int ref_sign(int k);
    return ($countones(k & (k >> 1)) % 2) ? -1 : 1;
  endfunction

  function automatic longint iabs(longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model_clear();
    win_i.delete();
    win_q.delete();
    for (int k = 0; k < L; k++) begin
      win_i.push_back(0);
      win_q.push_back(0);
    end
    m_state = 0;
    m_cnt   = 0;
    m_lp    = 0;
    e_valid = 0; e_frame = 0; e_pilot = 0; e_data = 0;
    e_i = 0; e_q = 0;
    e_tag = "R1";
  endtask

  task automatic model(bit v, int si, int sq);
    longint ci, cq, p;
    bit hit;
    e_valid = v;
    e_frame = 0; e_pilot = 0; e_data = 0;
    if (!v) begin
      e_tag = "R10";
      return;
    end
    win_i.push_back(si); void'(win_i.pop_front());
    win_q.push_back(sq); void'(win_q.pop_front());
    ci = 0; cq = 0; p = 0;
    for (int k = 0; k < L; k++) begin
      ci += ref_sign(k) * win_i[k];
      cq += ref_sign(k) * win_q[k];
      p  += iabs(win_i[k]) + iabs(win_q[k]);
    end
    hit = (p >= 2048) && ((ci * ci + cq * cq) * 256 > longint'(cfg_thr) * p * p);
    e_i = si;
    e_q = sq;
    if (m_state == 0) begin
      e_tag = phase_tag;
      if (hit) begin
        e_frame = 1;
        e_tag   = "R4";
        m_state = 1;
        m_cnt   = 0;
        m_lp    = cfg_lp;
      end
    end else if (m_state == 1) begin
      e_tag = hit ? "R9" : "R6";
      m_cnt++;
      if (m_cnt == TRAIN) begin
        m_state = 2;
        m_cnt   = 0;
      end
    end else begin
      e_tag   = hit ? "R9" : ((cfg_lp != m_lp) ? "R8" : "R7");
      e_pilot = (m_cnt % GRP) < m_lp;
      e_data  = !e_pilot;
      m_cnt++;
      if (m_cnt == DATA) begin
        m_state = 0;
        m_cnt   = 0;
      end
    end
  endtask

  task automatic compare();
    vectors++;
    if (out_valid !== e_valid) miss(e_tag, "out_valid", out_valid, e_valid);
    if (frame_start !== e_frame) miss(e_tag, "frame_start", frame_start, e_frame);
    if (pilot_flag !== e_pilot) miss(e_tag, "pilot_flag", pilot_flag, e_pilot);
    if (data_flag !== e_data) miss(e_tag, "data_flag", data_flag, e_data);
    if (e_valid && ($signed(out_i) != e_i || $signed(out_q) != e_q))
      miss("R2", "sample", {out_i, out_q}, {8'(e_i), 8'(e_q)});
    if (frame_start === 1'b1) dut_frames++;
  endtask

  task automatic cycle(bit v, int si, int sq);
    @(negedge clk);
    compare();
    in_valid   = v;
    in_i       = 8'(si);
    in_q       = 8'(sq);
    det_thresh = 8'(cfg_thr);
    pilot_reps = 5'(cfg_lp);
    model(v, si, sq);
  endtask

  function automatic int noise();
    return int'($urandom_range(40)) - 20;
  endfunction

  task automatic send_noise(int n, bit gaps);
    for (int k = 0; k < n; k++) begin
      bit v;
      v = gaps ? ($urandom_range(3) != 0) : 1'b1;
      cycle(v, noise(), noise());
    end
  endtask

  task automatic send_pre(int gi, int gq, bit flip, int first, int last);
    for (int k = first; k <= last; k++) begin
      int s;
      s = ref_sign(k);
      if (flip && k >= L / 2) s = -s;
      cycle(1'b1, s * gi, s * gq);
    end
  endtask

  task automatic finish_frame(bit gaps);
    while (m_state != 0) send_noise(1, gaps);
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    model_clear();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      vectors++;
      // R1: reset state at the ports
      if (out_valid || frame_start || pilot_flag || data_flag)
        miss("R1", "outputs in reset", {out_valid, frame_start, pilot_flag, data_flag}, 0);
      in_valid = $urandom_range(1);
      in_i     = 8'(noise());
    end
    in_valid = 1'b0;
    rst_n    = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    vectors = 0; misses = 0; dut_frames = 0;
    cfg_thr = 100; cfg_lp = 4; phase_tag = "R5";
    in_valid = 1'b0; in_i = '0; in_q = '0;
    det_thresh = 8'd100; pilot_reps = 5'd4;
    rst_n = 1'b0;
    model_clear();
    do_reset(4);

    // R5: noise alone must not detect
    phase_tag = "R5";
    send_noise(300, 1'b1);

    // R3: second half negated makes C zero
    phase_tag = "R3";
    send_pre(60, 0, 1'b1, 0, L - 1);
    send_noise(200, 1'b0);

    // R5: moderate match under a high threshold
    phase_tag = "R5";
    cfg_thr = 255;
    send_pre(50, 50, 1'b0, 0, L - 1);
    send_noise(150, 1'b0);

    // R4 R7 R10: frame with gaps, lambda 4
    cfg_thr = 100; cfg_lp = 4;
    send_pre(60, -30, 1'b0, 0, L - 1);
    send_noise(TRAIN + 900, 1'b1);
    // R8: density change mid-frame, R9: embedded preamble ignored
    cfg_lp = 1;
    send_pre(60, 0, 1'b0, 0, L - 1);
    finish_frame(1'b0);

    // R9: back-to-back re-arm, lambda 8
    cfg_lp = 8;
    send_pre(40, 0, 1'b0, 0, L - 1);
    finish_frame(1'b1);

    // R7: lambda 0, purely quadrature burst
    cfg_lp = 0;
    send_noise(40, 1'b0);
    send_pre(0, 70, 1'b0, 0, L - 1);
    finish_frame(1'b0);

    // R7: lambda above group length, every data symbol a pilot
    cfg_lp = 20;
    send_pre(-50, 25, 1'b0, 0, L - 1);
    finish_frame(1'b0);

    // R1: preamble split by reset is not detected
    phase_tag = "R1";
    send_pre(60, 0, 1'b0, 0, 99);
    do_reset(3);
    send_pre(60, 0, 1'b0, 100, L - 1);
    send_noise(60, 1'b0);
    cycle(1'b0, 0, 0);

    vectors++;
    // R4: exactly the four intended detections occurred
    if (dut_frames != 4) miss("R4", "frame count", dut_frames, 4);

    summary();
    $finish;
  end

endmodule